// File: doc/BRIEF.md
# Debug-aware reset mode controller

This block decides which parts of the chip are held in reset. It looks at three synchronized pins: a mode-select pin, an active-low system reset and an active-low debug-port reset. A fourth input says whether the emulator is running its own firmware (break) or the user program (user). It drives a CPU reset, a reset for the on-chip debug unit, an enable for that debug unit and a flag that shows a latched reset-hold state.

In normal mode the outputs follow the pin combination directly. In emulation mode two things are added. First, a system reset pulse is masked while the emulator firmware is running. Second, holding both resets low for a configurable number of clock cycles latches a hold state. The hold keeps the CPU in reset after the pins are released, while the debug unit can still be brought up. The hold ends only on a fresh high-to-low edge of either reset pin.

Top module: `rst_hold_ctrl`

## Requirements
- R1: `modeSel` = 1 selects normal mode and `modeSel` = 0 selects emulation mode. With the same pins, a system reset low / debug reset high pattern with `breakMode` = 1 asserts `cpuRst` in normal mode and does not assert it in emulation mode.
- R2: In normal mode, with `sysRstN`=0 and `dbgRstN`=0, both `cpuRst` and `dbgUnitRst` are 1. With `sysRstN`=0 and `dbgRstN`=1, only `cpuRst` is 1. `breakMode` has no effect in normal mode.
- R3: In either mode, with `sysRstN`=1 and `dbgRstN`=0, only `dbgUnitRst` is 1. With both pins 1 and no hold, `cpuRst` and `dbgUnitRst` are 0. `dbgEnable` is 1 exactly when `dbgRstN` is 1.
- R4: In emulation mode, with `sysRstN`=0 and `dbgRstN`=1, `cpuRst` is 1 when `breakMode`=0 (user) and 0 when `breakMode`=1 (break). With both pins 0, both `cpuRst` and `dbgUnitRst` are 1.
- R5: In emulation mode, `holdActive` becomes 1 after the clock edge at which both pins have been sampled low on `HOLD_CYCLES` consecutive edges. A shorter run does not set it, and the run count restarts whenever either pin is high. In normal mode `holdActive` is never set.
- R6: While `holdActive` is 1, `cpuRst` is 1 for every pin pattern and break setting. `dbgUnitRst` and `dbgEnable` still follow `dbgRstN`.
- R7: `holdActive` returns to 0 after the clock edge at which `sysRstN` or `dbgRstN` is sampled low having been sampled high at the previous edge.
- R8: `holdActive` is 0 while `porN` is low and after it is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| porN | input | 1 | Active-low power-up reset, clears the hold state |
| modeSel | input | 1 | Synchronized mode pin: 1 normal, 0 emulation |
| sysRstN | input | 1 | Synchronized active-low system reset |
| dbgRstN | input | 1 | Synchronized active-low debug-port reset |
| breakMode | input | 1 | 1 emulator firmware running, 0 user program running |
| cpuRst | output | 1 | CPU reset, active high |
| dbgUnitRst | output | 1 | Debug-unit reset, active high |
| dbgEnable | output | 1 | Debug unit allowed to operate |
| holdActive | output | 1 | Reset-hold state is latched |

## Verification
The bench builds the block with `HOLD_CYCLES` at its default of 4. At this value the hold boundary can be reached in a few cycles: a run of three low samples must not latch the hold, the fourth must latch it, and a release after three samples must restart the count. The same small threshold leaves room to walk all four pin patterns in both modes and both break settings, each held briefly, and then to enter and leave the hold through both clearing edges.

// File: rtl/rst_mode_pkg.sv
package rst_mode_pkg;

  // Strobes from the control to the hold datapath
  typedef struct packed {
    logic cntInc;   // advance the low-run counter
    logic cntClr;   // restart the low-run counter
    logic holdSet;  // latch the hold state
    logic holdClr;  // drop the hold state (fresh reset edge)
  } holdCtl_t;

endpackage

// File: rtl/rst_mode_ctrl.sv
module rst_mode_ctrl
  import rst_mode_pkg::*;
(
  input  logic     clk,
  input  logic     porN,
  input  logic     modeSel,
  input  logic     sysRstN,
  input  logic     dbgRstN,
  input  logic     breakMode,
  input  logic     atLast,
  output holdCtl_t ctl,
  output logic     cpuRstDec,
  output logic     dbgRstDec
);

  localparam int NPINS = 2;

  logic [NPINS-1:0] pinNow;
  logic [NPINS-1:0] pinPrev;
  logic [NPINS-1:0] pinFall;
  logic             emuMode;
  logic             bothLow;

  assign pinNow  = {sysRstN, dbgRstN};
  assign emuMode = ~modeSel;
  assign bothLow = ~sysRstN & ~dbgRstN;

  // Registered copies of each pin for edge detection
  for (genvar i = 0; i < NPINS; i++) begin : g_edge
    always_ff @(posedge clk or negedge porN) begin
      if (!porN) pinPrev[i] <= 1'b1;
      else       pinPrev[i] <= pinNow[i];
    end
    assign pinFall[i] = pinPrev[i] & ~pinNow[i];
  end

  // Direct decode of the pin pattern
  always_comb begin
    cpuRstDec = 1'b0;
    dbgRstDec = 1'b0;
    unique case ({sysRstN, dbgRstN})
      2'b00: begin
        cpuRstDec = 1'b1;
        dbgRstDec = 1'b1;
      end
      2'b01:   cpuRstDec = modeSel | ~breakMode;
      2'b10:   dbgRstDec = 1'b1;
      default: ;
    endcase
  end

  // Hold sequencing strobes
  always_comb begin
    ctl.holdClr = |pinFall;
    ctl.holdSet = emuMode & bothLow & atLast;
    ctl.cntInc  = emuMode & bothLow & ~atLast;
    ctl.cntClr  = ~(emuMode & bothLow);
  end

endmodule

// File: rtl/rst_mode_hold.sv
module rst_mode_hold
  import rst_mode_pkg::*;
#(
  parameter int HOLD_CYCLES = 4
) (
  input  logic     clk,
  input  logic     porN,
  input  holdCtl_t ctl,
  output logic     atLast,
  output logic     holdFlag
);

  localparam int CNT_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] lowCnt;

  assign atLast = (lowCnt == LAST);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)           lowCnt <= '0;
    else if (ctl.cntClr) lowCnt <= '0;
    else if (ctl.cntInc) lowCnt <= lowCnt + 1'b1;
  end

  // A fresh reset edge wins over a set in the same cycle
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)            holdFlag <= 1'b0;
    else if (ctl.holdClr) holdFlag <= 1'b0;
    else if (ctl.holdSet) holdFlag <= 1'b1;
  end

endmodule

// File: rtl/rst_hold_ctrl.sv
module rst_hold_ctrl
  import rst_mode_pkg::*;
#(
  parameter int HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic porN,
  input  logic modeSel,
  input  logic sysRstN,
  input  logic dbgRstN,
  input  logic breakMode,
  output logic cpuRst,
  output logic dbgUnitRst,
  output logic dbgEnable,
  output logic holdActive
);

  holdCtl_t ctl;
  logic     atLast;
  logic     cpuRstDec;
  logic     dbgRstDec;
  logic     holdFlag;

  rst_mode_ctrl ctrlI (
    .clk       (clk),
    .porN      (porN),
    .modeSel   (modeSel),
    .sysRstN   (sysRstN),
    .dbgRstN   (dbgRstN),
    .breakMode (breakMode),
    .atLast    (atLast),
    .ctl       (ctl),
    .cpuRstDec (cpuRstDec),
    .dbgRstDec (dbgRstDec)
  );

  rst_mode_hold #(.HOLD_CYCLES(HOLD_CYCLES)) holdI (
    .clk      (clk),
    .porN     (porN),
    .ctl      (ctl),
    .atLast   (atLast),
    .holdFlag (holdFlag)
  );

  assign cpuRst     = cpuRstDec | holdFlag;
  assign dbgUnitRst = dbgRstDec;
  assign dbgEnable  = ~dbgRstDec;
  assign holdActive = holdFlag;

endmodule

// File: rtl/rst_hold_ctrl_chk.sv
module rst_hold_ctrl_chk #(
  parameter int HOLD_CYCLES = 4
) (
  input logic clk,
  input logic porN,
  input logic modeSel,
  input logic sysRstN,
  input logic dbgRstN,
  input logic breakMode,
  input logic cpuRst,
  input logic dbgUnitRst,
  input logic dbgEnable,
  input logic holdActive
);

  // Consecutive emulation-mode edges with both pins low, saturating
  int lowRun;
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                                 lowRun <= 0;
    else if (!modeSel && !sysRstN && !dbgRstN) lowRun <= (lowRun > HOLD_CYCLES) ? lowRun : lowRun + 1;
    else                                       lowRun <= 0;
  end

  // R5
  hold_entry_len_chk: assert property (@(posedge clk) disable iff (!porN)
    $rose(holdActive) |-> (lowRun >= HOLD_CYCLES));

  // R6
  hold_keeps_cpu_chk: assert property (@(posedge clk) disable iff (!porN)
    holdActive |-> cpuRst);

  // R7
  hold_exit_edge_chk: assert property (@(posedge clk) disable iff (!porN)
    $fell(holdActive) |-> (($past(sysRstN, 2) && !$past(sysRstN)) ||
                           ($past(dbgRstN, 2) && !$past(dbgRstN))));

  // R4
  break_mask_chk: assert property (@(posedge clk) disable iff (!porN)
    (!modeSel && breakMode && !sysRstN && dbgRstN && !holdActive) |-> !cpuRst);

  // R3
  dbg_follow_chk: assert property (@(posedge clk) disable iff (!porN)
    !dbgRstN |-> (dbgUnitRst && !dbgEnable));

  // R3
  run_idle_chk: assert property (@(posedge clk) disable iff (!porN)
    (sysRstN && dbgRstN && !holdActive) |-> (!cpuRst && !dbgUnitRst && dbgEnable));

  // R5
  normal_no_hold_chk: assert property (@(posedge clk) disable iff (!porN)
    (modeSel && !$past(holdActive)) |-> !holdActive);

endmodule

bind rst_hold_ctrl rst_hold_ctrl_chk #(.HOLD_CYCLES(HOLD_CYCLES)) chkI (.*);

// File: tb/rst_hold_ctrl_test.sv
`timescale 1ns/1ps
module rst_hold_ctrl_test;

  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic porN, modeSel, sysRstN, dbgRstN, breakMode;
  logic cpuRst, dbgUnitRst, dbgEnable, holdActive;
  int   nChecks = 0;
  int   nFails  = 0;
  bit   finished = 1'b0;

  always #2.5 clk = ~clk;

  rst_hold_ctrl #(.HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .porN(porN), .modeSel(modeSel), .sysRstN(sysRstN),
    .dbgRstN(dbgRstN), .breakMode(breakMode), .cpuRst(cpuRst),
    .dbgUnitRst(dbgUnitRst), .dbgEnable(dbgEnable), .holdActive(holdActive)
  );

  // Compare {cpuRst, dbgUnitRst, dbgEnable, holdActive}
  task automatic chk(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {cpuRst, dbgUnitRst, dbgEnable, holdActive};
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: {cpu,dbgRst,dbgEn,hold} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic setPins(input logic s, input logic d);
    sysRstN = s;
    dbgRstN = d;
    #1;
  endtask

  function automatic logic [3:0] decodeExp(input logic m, input logic b,
                                           input logic s, input logic d);
    logic c;
    if (!s && !d) c = 1'b1;
    else if (!s)  c = m | ~b;
    else          c = 1'b0;
    return {c, ~d, d, 1'b0};
  endfunction

  task automatic testReset();
    porN = 1'b0; modeSel = 1'b0; breakMode = 1'b0;
    sysRstN = 1'b1; dbgRstN = 1'b1;
    step(3);
    #1;
    chk("R8 during reset", 4'b0010);
    porN = 1'b1;
    step(1);
    #1;
    chk("R8 after reset", 4'b0010);
  endtask

  task automatic walkTable(input logic m, input string tag);
    modeSel = m;
    for (int b = 0; b < 2; b++) begin
      breakMode = b[0];
      for (int p = 0; p < 4; p++) begin
        setPins(p[1], p[0]);
        chk(tag, decodeExp(m, b[0], p[1], p[0]));
        step(1);
        setPins(1'b1, 1'b1);
        step(1);
      end
    end
  endtask

  task automatic testModeSelect();
    breakMode = 1'b1;
    modeSel = 1'b1;
    setPins(1'b0, 1'b1);
    chk("R1 normal mode reset pin honoured", 4'b1010);
    modeSel = 1'b0;
    #1;
    chk("R1 emulation break masks reset pin", 4'b0010);
    setPins(1'b1, 1'b1);
    step(1);
  endtask

  task automatic testNormalNoHold();
    modeSel = 1'b1; breakMode = 1'b0;
    setPins(1'b0, 1'b0);
    step(HOLD + 2);
    chk("R5 normal mode both low", 4'b1100);
    setPins(1'b1, 1'b1);
    chk("R5 normal mode never holds", 4'b0010);
    step(1);
  endtask

  task automatic testShortRun();
    modeSel = 1'b0; breakMode = 1'b0;
    setPins(1'b0, 1'b0);
    step(HOLD - 1);
    chk("R5 short run no hold", 4'b1100);
    setPins(1'b1, 1'b1);
    step(1);
    chk("R5 release after short run", 4'b0010);
    setPins(1'b0, 1'b0);
    step(HOLD - 1);
    chk("R5 count restarted", 4'b1100);
    setPins(1'b1, 1'b1);
    step(1);
  endtask

  task automatic enterHold();
    modeSel = 1'b0;
    setPins(1'b0, 1'b0);
    step(HOLD - 1);
    chk("R5 one sample before threshold", 4'b1100);
    step(1);
    chk("R5 hold latched at threshold", 4'b1101);
  endtask

  task automatic testHoldAndSysClear();
    breakMode = 1'b0;
    enterHold();
    setPins(1'b1, 1'b0);
    step(2);
    chk("R6 hold with system reset high", 4'b1101);
    setPins(1'b1, 1'b1);
    chk("R6 debug up cpu held", 4'b1011);
    step(3);
    chk("R6 hold persists", 4'b1011);
    breakMode = 1'b1;
    #1;
    chk("R6 hold ignores break setting", 4'b1011);
    breakMode = 1'b0;
    setPins(1'b0, 1'b1);
    chk("R7 before system reset edge sampled", 4'b1011);
    step(1);
    chk("R7 cleared by system reset edge", 4'b1010);
    setPins(1'b1, 1'b1);
    chk("R7 cpu runs after clear", 4'b0010);
    step(1);
  endtask

  task automatic testDbgClear();
    breakMode = 1'b1;
    enterHold();
    setPins(1'b1, 1'b1);
    step(2);
    chk("R6 hold in break mode", 4'b1011);
    setPins(1'b0, 1'b1);
    chk("R6 masked pin but hold keeps cpu", 4'b1011);
    setPins(1'b1, 1'b1);
    step(1);
    setPins(1'b1, 1'b0);
    chk("R7 before debug reset edge sampled", 4'b1101);
    step(1);
    chk("R7 cleared by debug reset edge", 4'b0100);
    setPins(1'b1, 1'b1);
    chk("R7 idle after debug clear", 4'b0010);
    step(2);
    chk("R7 stays clear", 4'b0010);
  endtask

  initial begin
    testReset();
    walkTable(1'b1, "R2 R3 normal table");
    walkTable(1'b0, "R3 R4 emulation table");
    testModeSelect();
    testNormalNoHold();
    testShortRun();
    testHoldAndSysClear();
    testDbgClear();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule